// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad Arbiter

This block is a shared on-chip scratchpad built from word-interleaved single-port banks. A group of parallel lanes presents one request, in which every lane may carry a load or a store. The block finds the lanes that collide on a bank and runs the request over as many passes as the worst collision needs. In every pass each bank serves exactly one word. Lanes that ask for the same word are served together: reads get the word by broadcast, and stores to it resolve to a single winner.

The group handshake is a ready/valid pair. After a request is accepted, ready stays low until every active lane has been retired. A one-cycle done pulse then marks the cycle in which all read data and the pass count are valid. There are three operating modes. The full mode uses 32 banks and 32 lanes. The narrow mode uses 16 banks served by lanes 0 to 15. The wide mode handles 64-bit lane accesses as two transactions, one for each half of the lane group.

Top module: `bank_scratch_arb`

## Requirements
- R1: Word w lives in physical bank w mod 32 at row w/32. In mode_i=0, 32 lanes that touch 32 consecutive words complete in one pass, and a later read returns the data written.
- R2: Lanes that touch different words mapping to the same logical bank are served in separate passes. At done, passes_o equals the sum over transactions of the largest number of distinct words on any one bank. With mode_i=0, reads at word strides 2, 4, 8 and 32 give 2, 4, 8 and 32.
- R3: With mode_i=1 the logical bank is the word address mod 16 and only lanes 0 to 15 take part. Lanes 16 to 31 change no memory word and return zero read data.
- R4: Any number of lanes reading the same word in one request all receive that word, and together they add only one pass.
- R5: When several lanes store to the same word in one request, the data of the highest-numbered of those lanes is the value left in memory.
- R6: With mode_i=2, bit 0 of a lane address is ignored. The lane accesses word {a[9:1],0} as data bits 31:0 and word {a[9:1],1} as bits 63:32. Lanes 0 to 15 are served first, then lanes 16 to 31, and the second transaction sees the stores of the first. 16 lanes with consecutive element addresses need one pass per transaction.
- R7: A read of a word that is stored to within the same transaction returns the value the word held before that transaction.
- R8: req_ready_o is high when idle. It falls in the cycle after a request is accepted (req_valid_i and req_ready_o both high) and stays low until done_o. done_o is high for exactly one cycle, and req_ready_o is high again in the next cycle.
- R9: lane_rdata_o is valid in the done cycle and is held until the next accept. A lane that did not read returns zero. passes_o is valid at done, and a request with no valid lane reports 0 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Group request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| mode_i | input | 2 | 0 full 32-bank, 1 narrow 16-bank, 2 wide 64-bit, 3 acts as 0 |
| lane_vld_i | input | 32 | Per-lane access enable |
| lane_we_i | input | 32 | Per-lane store (1) or load (0) |
| lane_addr_i | input | 320 | Per-lane word address, lane i at bits [10i+9:10i] |
| lane_wdata_i | input | 2048 | Per-lane store data, lane i at bits [64i+63:64i] |
| lane_rdata_o | output | 2048 | Per-lane load data, same packing as store data |
| done_o | output | 1 | One-cycle pulse when the request has fully retired |
| passes_o | output | 7 | Number of bank passes used by the last request |

## Verification
A wrong leader choice or a lost pending bit in the scheduler shows up in the done cycle of the same request. passes_o is then off from the per-bank distinct-word count, or some lane returns zero or stale data instead of the expected word. A bank that is written at the wrong row, or written with the wrong collision winner, shows nothing until that word is read again, which may be many requests later. For that reason the whole memory is filled and read back, and random traffic is confined to a small address window so that corrupted words are soon read back. A phase error in wide mode shows as swapped halves or as second-half lanes that miss the first half's stores.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int LANES  = 32;
    localparam int BANKS  = 32;
    localparam int DW     = 32;
    localparam int AW     = 10;

    localparam int SLOTS  = LANES;
    localparam int HALF_L = LANES / 2;
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = AW - BANK_W;
    localparam int DEPTH  = 1 << ROW_W;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int PASS_W = $clog2(2 * SLOTS + 1);

    typedef enum logic [1:0] {
        MODE_W32 = 2'd0,
        MODE_N16 = 2'd1,
        MODE_W64 = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_FIN,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic          vld;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    function automatic mode_e norm_mode(input logic [1:0] m);
        mode_e r;
        if (m == 2'd1)      r = MODE_N16;
        else if (m == 2'd2) r = MODE_W64;
        else                r = MODE_W32;
        return r;
    endfunction

    // logical bank used for conflict detection
    function automatic logic [BANK_W-1:0] lbank(input logic [AW-1:0] a, input mode_e m);
        logic [BANK_W-1:0] b;
        b = a[BANK_W-1:0];
        if (m == MODE_N16) b[BANK_W-1] = 1'b0;
        return b;
    endfunction

    function automatic logic [BANK_W-1:0] pbank(input logic [AW-1:0] a);
        return a[BANK_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] prow(input logic [AW-1:0] a);
        return a[AW-1:BANK_W];
    endfunction

    function automatic logic [SLOT_W-1:0] dest_lane(input mode_e m, input logic ph,
                                                    input logic [SLOT_W-1:0] s);
        logic [SLOT_W-1:0] l;
        if (m == MODE_W64) l = {ph, s[SLOT_W-1:1]};
        else               l = s;
        return l;
    endfunction

    function automatic logic dest_half(input mode_e m, input logic [SLOT_W-1:0] s);
        return (m == MODE_W64) ? s[0] : 1'b0;
    endfunction

endpackage

// File: rtl/spm_slot_loader.sv
module spm_slot_loader
    import spm_pkg::*;
(
    input  mode_e                       mode_i,
    input  logic                        phase_i,
    input  logic [LANES-1:0]            vld_i,
    input  logic [LANES-1:0]            we_i,
    input  logic [LANES-1:0][AW-1:0]    addr_i,
    input  logic [LANES-1:0][2*DW-1:0]  wdata_i,
    output slot_t [SLOTS-1:0]           slots_o
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [SLOT_W-1:0] LN_LO = SLOT_W'(s / 2);
        localparam logic [SLOT_W-1:0] LN_HI = SLOT_W'(HALF_L + s / 2);
        localparam logic              HBIT  = 1'(s % 2);
        localparam logic              UPPER = (s >= HALF_L);

        logic [SLOT_W-1:0] ln;

        always_comb begin
            if (mode_i == MODE_W64) ln = phase_i ? LN_HI : LN_LO;
            else                    ln = SLOT_W'(s);

            slots_o[s].we = we_i[ln];
            if (mode_i == MODE_W64) begin
                slots_o[s].vld  = vld_i[ln];
                slots_o[s].addr = {addr_i[ln][AW-1:1], HBIT};
                slots_o[s].data = HBIT ? wdata_i[ln][2*DW-1:DW] : wdata_i[ln][DW-1:0];
            end else begin
                slots_o[s].vld  = vld_i[ln] && !((mode_i == MODE_N16) && UPPER);
                slots_o[s].addr = addr_i[ln];
                slots_o[s].data = wdata_i[ln][DW-1:0];
            end
        end
    end

endmodule

// File: rtl/spm_pass_picker.sv
module spm_pass_picker
    import spm_pkg::*;
(
    input  mode_e                       mode_i,
    input  slot_t [SLOTS-1:0]           slots_i,
    input  logic  [SLOTS-1:0]           pending_i,
    output logic  [SLOTS-1:0]           served_o,
    output logic  [BANKS-1:0]           bank_en_o,
    output logic  [BANKS-1:0]           bank_we_o,
    output logic  [BANKS-1:0][ROW_W-1:0] bank_row_o,
    output logic  [BANKS-1:0][DW-1:0]   bank_wd_o
);

    logic [SLOTS-1:0] leader;

    // leader: lowest pending slot on its logical bank
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            leader[s] = pending_i[s];
            for (int t = 0; t < SLOTS; t++) begin
                if (t < s && pending_i[t] &&
                    lbank(slots_i[t].addr, mode_i) == lbank(slots_i[s].addr, mode_i))
                    leader[s] = 1'b0;
            end
        end
    end

    // a slot retires when a leader holds its exact word
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            served_o[s] = 1'b0;
            for (int t = 0; t < SLOTS; t++) begin
                if (t <= s && leader[t] && slots_i[t].addr == slots_i[s].addr)
                    served_o[s] = pending_i[s];
            end
        end
    end

    // per physical bank: one word, highest store wins
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_en_o[b]  = 1'b0;
            bank_we_o[b]  = 1'b0;
            bank_row_o[b] = '0;
            bank_wd_o[b]  = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (served_o[s] && pbank(slots_i[s].addr) == BANK_W'(b)) begin
                    bank_en_o[b]  = 1'b1;
                    bank_row_o[b] = bank_row_o[b] | prow(slots_i[s].addr);
                    if (slots_i[s].we) begin
                        bank_we_o[b] = 1'b1;
                        bank_wd_o[b] = slots_i[s].data;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spm_bank.sv
module spm_bank
    import spm_pkg::*;
(
    input  logic             clk_i,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o
);

    logic [DW-1:0] mem [DEPTH];

    // read-first single port
    always_ff @(posedge clk_i) begin
        if (en_i) begin
            rdata_o <= mem[row_i];
            if (we_i) mem[row_i] <= wdata_i;
        end
    end

endmodule

// File: rtl/bank_scratch_arb.sv
module bank_scratch_arb
    import spm_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [1:0]               mode_i,
    input  logic [LANES-1:0]         lane_vld_i,
    input  logic [LANES-1:0]         lane_we_i,
    input  logic [LANES*AW-1:0]      lane_addr_i,
    input  logic [LANES*2*DW-1:0]    lane_wdata_i,
    output logic [LANES*2*DW-1:0]    lane_rdata_o,
    output logic                     done_o,
    output logic [PASS_W-1:0]        passes_o
);

    localparam logic [PASS_W-1:0] LIM_ONE = PASS_W'(SLOTS);
    localparam logic [PASS_W-1:0] LIM_TWO = PASS_W'(2 * SLOTS);

    state_e                       state_q;
    mode_e                        mode_q;
    logic                         phase_q;
    logic [LANES-1:0]             vld_q;
    logic [LANES-1:0]             we_q;
    logic [LANES-1:0][AW-1:0]     addr_q;
    logic [LANES-1:0][2*DW-1:0]   wdata_q;
    logic [SLOTS-1:0]             pending_q;
    logic [PASS_W-1:0]            passes_q;

    slot_t [SLOTS-1:0]            slots;
    logic  [SLOTS-1:0]            slot_vld;
    logic  [SLOTS-1:0]            slot_rd;
    logic  [SLOTS-1:0]            served;
    logic  [SLOTS-1:0]            remain;

    logic  [BANKS-1:0]            bank_en;
    logic  [BANKS-1:0]            bank_we;
    logic  [BANKS-1:0][ROW_W-1:0] bank_row;
    logic  [BANKS-1:0][DW-1:0]    bank_wd;
    logic  [BANKS-1:0][DW-1:0]    bank_rd;

    logic  [SLOTS-1:0]             cap_q;
    logic  [SLOTS-1:0][BANK_W-1:0] cap_pb_q;
    logic                          cap_ph_q;
    logic  [LANES-1:0][1:0][DW-1:0] rdata_q;

    logic accept;

    assign req_ready_o  = (state_q == ST_IDLE);
    assign done_o       = (state_q == ST_DONE);
    assign accept       = req_valid_i && req_ready_o;
    assign passes_o     = passes_q;
    assign lane_rdata_o = rdata_q;
    assign remain       = pending_q & ~served;

    spm_slot_loader u_loader (
        .mode_i  (mode_q),
        .phase_i (phase_q),
        .vld_i   (vld_q),
        .we_i    (we_q),
        .addr_i  (addr_q),
        .wdata_i (wdata_q),
        .slots_o (slots)
    );

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            slot_vld[s] = slots[s].vld;
            slot_rd[s]  = !slots[s].we;
        end
    end

    spm_pass_picker u_picker (
        .mode_i     (mode_q),
        .slots_i    (slots),
        .pending_i  (pending_q),
        .served_o   (served),
        .bank_en_o  (bank_en),
        .bank_we_o  (bank_we),
        .bank_row_o (bank_row),
        .bank_wd_o  (bank_wd)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spm_bank u_bank (
            .clk_i   (clk_i),
            .en_i    (bank_en[b]),
            .we_i    (bank_we[b]),
            .row_i   (bank_row[b]),
            .wdata_i (bank_wd[b]),
            .rdata_o (bank_rd[b])
        );
    end

    // request sequencing
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_W32;
            phase_q   <= 1'b0;
            vld_q     <= '0;
            we_q      <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            pending_q <= '0;
            passes_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q   <= norm_mode(mode_i);
                        vld_q    <= lane_vld_i;
                        we_q     <= lane_we_i;
                        addr_q   <= lane_addr_i;
                        wdata_q  <= lane_wdata_i;
                        phase_q  <= 1'b0;
                        passes_q <= '0;
                        state_q  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    pending_q <= slot_vld;
                    state_q   <= ST_RUN;
                end
                ST_RUN: begin
                    pending_q <= remain;
                    if (|pending_q) passes_q <= passes_q + PASS_W'(1);
                    if (remain == '0) begin
                        if (mode_q == MODE_W64 && !phase_q) begin
                            phase_q <= 1'b1;
                            state_q <= ST_LOAD;
                        end else begin
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_FIN:  state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // read return: bank output one cycle after its pass, then lane register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_q    <= '0;
            cap_pb_q <= '0;
            cap_ph_q <= 1'b0;
        end else begin
            cap_q    <= (state_q == ST_RUN) ? (served & slot_rd) : '0;
            cap_ph_q <= phase_q;
            for (int s = 0; s < SLOTS; s++) cap_pb_q[s] <= pbank(slots[s].addr);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (cap_q[s])
                    rdata_q[dest_lane(mode_q, cap_ph_q, SLOT_W'(s))][dest_half(mode_q, SLOT_W'(s))]
                        <= bank_rd[cap_pb_q[s]];
            end
        end
    end

    AST_PASS_PROGRESS: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && |pending_q) |-> |served); // R2

    AST_NARROW_UPPER_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && mode_q == MODE_N16) |-> (served[SLOTS-1:HALF_L] == '0)); // R3

    AST_READY_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        accept |=> !req_ready_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!done_o && req_ready_o)); // R8

    AST_PASS_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (passes_o <= ((mode_q == MODE_W64) ? LIM_TWO : LIM_ONE))); // R9

endmodule

// File: tb/bank_scratch_arb_tb.sv
module bank_scratch_arb_tb;
    import spm_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst;
    logic                   req_valid;
    logic [1:0]             mode;
    logic [LANES-1:0]       vld_f, we_f;
    logic [LANES*AW-1:0]    addr_f;
    logic [LANES*2*DW-1:0]  wdata_f;
    wire                    ready, done;
    wire [LANES*2*DW-1:0]   rdata_f;
    wire [PASS_W-1:0]       passes;

    int n_tests = 0;
    int n_fail  = 0;

    bank_scratch_arb u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .req_valid_i  (req_valid),
        .req_ready_o  (ready),
        .mode_i       (mode),
        .lane_vld_i   (vld_f),
        .lane_we_i    (we_f),
        .lane_addr_i  (addr_f),
        .lane_wdata_i (wdata_f),
        .lane_rdata_o (rdata_f),
        .done_o       (done),
        .passes_o     (passes)
    );

    // reference state
    logic [DW-1:0]   model [1 << AW];
    int              a_lane [LANES];
    logic [2*DW-1:0] d_lane [LANES];
    bit              v_lane [LANES];
    bit              w_lane [LANES];
    logic [DW-1:0]   exp_rd [LANES][2];

    int              s_a [SLOTS];
    bit              s_v [SLOTS];
    bit              s_w [SLOTS];
    logic [DW-1:0]   s_d [SLOTS];
    int              s_ln [SLOTS];
    int              s_hf [SLOTS];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    function automatic void clear_lanes();
        for (int i = 0; i < LANES; i++) begin
            a_lane[i] = 0; d_lane[i] = '0; v_lane[i] = 0; w_lane[i] = 0;
        end
    endfunction

    function automatic void build_slots(input int m, input int ph);
        for (int s = 0; s < SLOTS; s++) begin
            int ln;
            if (m == 2) begin
                ln = ph * HALF_L + s / 2;
                s_hf[s] = s % 2;
                s_a[s]  = (a_lane[ln] & ~1) | s_hf[s];
                s_v[s]  = v_lane[ln];
                s_d[s]  = s_hf[s] ? d_lane[ln][63:32] : d_lane[ln][31:0];
            end else begin
                ln = s;
                s_hf[s] = 0;
                s_a[s]  = a_lane[s];
                s_v[s]  = v_lane[s] && !(m == 1 && s >= HALF_L);
                s_d[s]  = d_lane[s][31:0];
            end
            s_ln[s] = ln;
            s_w[s]  = w_lane[ln];
        end
    endfunction

    // one transaction: reads see memory before it, stores apply in lane order
    function automatic int model_phase(input int m, input int ph);
        int cnt [BANKS];
        int best = 0;
        int nb = (m == 1) ? BANKS / 2 : BANKS;
        build_slots(m, ph);
        for (int b = 0; b < BANKS; b++) cnt[b] = 0;
        for (int s = 0; s < SLOTS; s++) begin
            if (s_v[s]) begin
                bit dup = 0;
                for (int t = 0; t < s; t++) if (s_v[t] && s_a[t] == s_a[s]) dup = 1;
                if (!dup) cnt[s_a[s] % nb]++;
                if (!s_w[s]) exp_rd[s_ln[s]][s_hf[s]] = model[s_a[s]];
            end
        end
        for (int s = 0; s < SLOTS; s++) if (s_v[s] && s_w[s]) model[s_a[s]] = s_d[s];
        for (int b = 0; b < BANKS; b++) if (cnt[b] > best) best = cnt[b];
        return best;
    endfunction

    task automatic run_req(input int m, input string tag);
        int  exp_p;
        bit  hs_ok;
        bit  rd_ok;
        int  wait_c;
        logic [63:0] act_w, exp_w;
        for (int i = 0; i < LANES; i++) begin exp_rd[i][0] = '0; exp_rd[i][1] = '0; end
        exp_p = model_phase(m, 0);
        if (m == 2) exp_p += model_phase(m, 1);

        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            vld_f[i] = v_lane[i];
            we_f[i]  = w_lane[i];
            addr_f[i*AW +: AW]       = AW'(a_lane[i]);
            wdata_f[i*2*DW +: 2*DW]  = d_lane[i];
        end
        mode = 2'(m);
        hs_ok = (ready === 1'b1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_c = 0;
        while (done !== 1'b1 && wait_c < 200) begin
            if (ready !== 1'b0) hs_ok = 0;
            @(negedge clk);
            wait_c++;
        end
        if (done !== 1'b1) hs_ok = 0;

        rd_ok = 1; act_w = '0; exp_w = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            logic [63:0] e;
            e = {exp_rd[i][1], exp_rd[i][0]};
            if (rdata_f[i*2*DW +: 2*DW] !== e) begin
                rd_ok = 0; act_w = rdata_f[i*2*DW +: 2*DW]; exp_w = e;
            end
        end
        chk(rd_ok, tag, "lane read data", act_w, exp_w);
        chk(passes === PASS_W'(exp_p), tag, "pass count", 64'(passes), 64'(exp_p));

        @(negedge clk);
        if (done !== 1'b0 || ready !== 1'b1) hs_ok = 0;
        chk(hs_ok, "R8", "handshake ready/done", {62'd0, ready, done}, 64'h2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; req_valid = 1'b0; mode = '0;
        vld_f = '0; we_f = '0; addr_f = '0; wdata_f = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready === 1'b1 && done === 1'b0 && passes === '0, "R8", "reset state",
            {56'd0, ready, done, 6'(passes)}, 64'h80);

        // R1: fill whole memory with stride-1 stores
        for (int r = 0; r < (1 << AW) / LANES; r++) begin
            clear_lanes();
            for (int i = 0; i < LANES; i++) begin
                v_lane[i] = 1; w_lane[i] = 1; a_lane[i] = r * LANES + i;
                d_lane[i] = {32'd0, $urandom()};
            end
            run_req(0, "R1");
        end

        // R1: stride-1 readback
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 64 + i; end
        run_req(0, "R1");

        // R2: strided reads
        for (int k = 0; k < 4; k++) begin
            int st;
            st = (k == 3) ? 32 : (2 << k);
            clear_lanes();
            for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = (i * st) % (1 << AW); end
            run_req(0, "R2");
        end

        // R4: all lanes read one word
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 77; end
        run_req(0, "R4");

        // R4/R2: broadcast plus one distinct word on the same bank
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 5; end
        a_lane[31] = 37;
        run_req(0, "R4");

        // R5/R7: all store one word, lane 0 reads it in the same request
        clear_lanes();
        for (int i = 1; i < LANES; i++) begin
            v_lane[i] = 1; w_lane[i] = 1; a_lane[i] = 100; d_lane[i] = {32'd0, 32'hA000 + 32'(i)};
        end
        v_lane[0] = 1; a_lane[0] = 100;
        run_req(0, "R7");
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 100; end
        run_req(0, "R5");

        // R3: narrow mode, upper lanes store but must have no effect
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin
            v_lane[i] = 1; a_lane[i] = (i < HALF_L) ? 200 + i : 300 + i;
            w_lane[i] = (i >= HALF_L); d_lane[i] = {32'd0, 32'hDEAD0000 + 32'(i)};
        end
        run_req(1, "R3");
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 300 + i; end
        run_req(0, "R3");
        // R3: 16-word stride hits one narrow bank: 16 passes
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 16 * i; end
        run_req(1, "R3");

        // R6: wide stores then wide reads
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin
            v_lane[i] = 1; w_lane[i] = 1; a_lane[i] = 512 + 2 * i + (i % 2);
            d_lane[i] = {$urandom(), $urandom()};
        end
        run_req(2, "R6");
        clear_lanes();
        for (int i = 0; i < LANES; i++) begin v_lane[i] = 1; a_lane[i] = 512 + 2 * i; end
        run_req(2, "R6");
        // R6: lane 16 reads the element lane 0 stores in the first half
        clear_lanes();
        v_lane[0] = 1; w_lane[0] = 1; a_lane[0] = 700; d_lane[0] = 64'h1111_2222_3333_4444;
        v_lane[16] = 1; a_lane[16] = 701;
        run_req(2, "R6");

        // R9: empty requests
        clear_lanes();
        run_req(0, "R9");
        run_req(2, "R9");

        // random traffic in a small window, mixed modes
        for (int n = 0; n < 60; n++) begin
            int m;
            m = int'($urandom() % 3);
            clear_lanes();
            for (int i = 0; i < LANES; i++) begin
                v_lane[i] = ($urandom() % 4) != 0;
                w_lane[i] = ($urandom() % 4) == 0;
                a_lane[i] = (n % 2 == 0) ? int'($urandom() % 96) : int'($urandom() % (1 << AW));
                d_lane[i] = {$urandom(), $urandom()};
            end
            run_req(m, "R2");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule